// File: doc/BRIEF.md
# Pseudo-Mersenne Modular Reduction Unit

This block takes a double-width integer, such as a 64-bit product or the sum kept by a multiply/accumulate unit, and reduces it modulo a prime of the form p = 2^n - c. The exponent n (up to 32) and the small constant c are supplied at run time, so one instance serves many moduli. The reduction rests on the congruence 2^n ≡ c (mod p). One fold keeps the bottom n bits of the value and adds c times the bits above position n. Three folds bring any legal operand below 2^n. A single conditional subtraction of p then yields the canonical residue.

The work can be issued in two separate commands. A fold command runs the three folds and leaves a partially reduced value. A settle command later applies the conditional subtraction to that held value. A full command runs all four steps back to back. Each command uses a start/busy/done handshake, and the result stays on the output until the next command completes.

Top module: `pmr_reduce`

## Requirements
- R1: After reset, busy_o and done_o are low and result_o is zero.
- R2: With op_i = 0 (full), result_o equals operand_i mod p, where p = 2^n - c. The operand must satisfy 2 ≤ n ≤ 32, 1 ≤ c < 2^15, c·(c+1) < 2^n and operand_i < 2^(2n).
- R3: A full command accepted at a rising edge raises done_o after the fourth rising edge, counting the accepting edge. busy_o is high in each cycle before that, and busy_o is low whenever done_o is high.
- R4: done_o stays high for one cycle only, unless a new command is accepted in that same cycle.
- R5: A start_i pulse while busy_o is high is ignored. result_o, the latency and the outcome of the running command are not affected, and result_o changes only in a cycle where done_o is high.
- R6: An operand below p is returned unchanged, and an operand equal to p gives zero.
- R7: With n = 32, operands that use all 64 bits are reduced correctly, up to and including 2^64 - 1.
- R8: With op_i = 1 (fold), done_o rises after the third rising edge. result_o equals f(f(f(x))), where f(x) = (x mod 2^n) + c·floor(x / 2^n).
- R9: With op_i = 2 (settle), done_o rises after the accepting edge and busy_o stays low. result_o becomes the previously held result minus p when that value is at least p, and the held value otherwise. operand_i is not used.
- R10: op_i = 3 behaves exactly like the full command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command request, taken when busy_o is low |
| op_i | input | 2 | Command: 0 full, 1 fold, 2 settle, 3 full |
| operand_i | input | 64 | Value to reduce (not used by settle) |
| exp_n_i | input | 6 | Exponent n of the modulus |
| coef_c_i | input | 15 | Constant c of the modulus |
| busy_o | output | 1 | High while a multi-cycle command runs |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result of the last completed command |

## Verification
The bench targets the ends of the residue range: operand p-1, operand p, exact multiples of p, and 2^64 - 1 with n = 32. A design that skips the final subtraction returns p instead of 0. A design that loses the top bit of the shift at n = 32 returns a value off by a multiple of c. Small moduli such as n = 2 and n = 5 expose a fold count that falls short, because the output is then left at or above 2^n. Fold followed by settle checks that the held intermediate is the exact triple-fold value and is not yet reduced. A start pulse injected mid-command catches a design that reloads its operand or configuration while busy.

// File: rtl/pmr_pkg.sv
`timescale 1ns/1ps
package pmr_pkg;
    localparam int PMR_WORD_W = 32;
    localparam int PMR_COEF_W = 15;

    typedef enum logic [1:0] {
        OP_FULL   = 2'd0,
        OP_FOLD   = 2'd1,
        OP_SETTLE = 2'd2,
        OP_ALT    = 2'd3
    } pmr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FOLD2,
        ST_FOLD3,
        ST_SUB
    } pmr_state_e;

    function automatic logic is_multi_cycle(pmr_op_e op);
        return op != OP_SETTLE;
    endfunction
endpackage

// File: rtl/pmr_fold.sv
`timescale 1ns/1ps
// One fold: keep the low n bits, add c times the part above bit n.
module pmr_fold #(
    parameter int IN_W   = 64,
    parameter int OUT_W  = 48,
    parameter int EXP_W  = 6,
    parameter int COEF_W = 15
) (
    input  logic [IN_W-1:0]   x_i,
    input  logic [EXP_W-1:0]  n_i,
    input  logic [COEF_W-1:0] c_i,
    output logic [OUT_W-1:0]  y_o
);
    logic [IN_W-1:0] mask;
    logic [IN_W-1:0] lo;
    logic [IN_W-1:0] hi;
    logic [IN_W-1:0] prod;

    always_comb begin
        mask = (IN_W'(1) << n_i) - IN_W'(1);
        lo   = x_i & mask;
        hi   = x_i >> n_i;
        prod = hi * IN_W'(c_i);
        y_o  = OUT_W'(lo + prod);
    end
endmodule

// File: rtl/pmr_csub.sv
`timescale 1ns/1ps
// Conditional subtraction of p = 2^n - c.
module pmr_csub #(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 48,
    parameter int EXP_W  = 6,
    parameter int COEF_W = 15
) (
    input  logic [ACC_W-1:0]  v_i,
    input  logic [EXP_W-1:0]  n_i,
    input  logic [COEF_W-1:0] c_i,
    output logic [WORD_W-1:0] r_o
);
    logic [ACC_W-1:0] p;
    logic [ACC_W-1:0] diff;

    always_comb begin
        p    = (ACC_W'(1) << n_i) - ACC_W'(c_i);
        diff = v_i - p;
        r_o  = (v_i >= p) ? WORD_W'(diff) : WORD_W'(v_i);
    end
endmodule

// File: rtl/pmr_ctrl.sv
`timescale 1ns/1ps
module pmr_ctrl
    import pmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  pmr_op_e op_i,
    output logic    fold_fresh_o,
    output logic    fold_en_o,
    output logic    res_fold_o,
    output logic    res_sub_o,
    output logic    settle_o,
    output logic    full_o,
    output logic    busy_o,
    output logic    done_o
);
    pmr_state_e st_q, st_d;
    logic       full_q;
    logic       done_q;
    logic       idle;
    logic       accept_any;
    logic       accept_fold;
    logic       accept_settle;

    always_comb begin
        idle          = (st_q == ST_IDLE);
        accept_any    = idle && start_i;
        accept_fold   = accept_any && is_multi_cycle(op_i);
        accept_settle = accept_any && !is_multi_cycle(op_i);
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept_fold) st_d = ST_FOLD2;
            ST_FOLD2: st_d = ST_FOLD3;
            ST_FOLD3: st_d = full_q ? ST_SUB : ST_IDLE;
            ST_SUB:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fold_fresh_o = accept_fold;
        fold_en_o    = accept_fold || (st_q == ST_FOLD2) || (st_q == ST_FOLD3 && full_q);
        res_fold_o   = (st_q == ST_FOLD3) && !full_q;
        res_sub_o    = (st_q == ST_SUB);
        settle_o     = accept_settle;
        full_o       = full_q;
        busy_o       = !idle;
        done_o       = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            full_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= res_fold_o || res_sub_o || accept_settle;
            if (accept_any) full_q <= (op_i != OP_FOLD);
        end
    end
endmodule

// File: rtl/pmr_reduce.sv
`timescale 1ns/1ps
module pmr_reduce
    import pmr_pkg::*;
#(
    parameter int WORD_W = PMR_WORD_W,
    parameter int COEF_W = PMR_COEF_W,
    localparam int OPND_W = 2 * WORD_W,
    localparam int EXP_W  = $clog2(WORD_W + 1),
    localparam int ACC_W  = WORD_W + COEF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [OPND_W-1:0] operand_i,
    input  logic [EXP_W-1:0]  exp_n_i,
    input  logic [COEF_W-1:0] coef_c_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o
);
    typedef struct packed {
        logic [EXP_W-1:0]  n;
        logic [COEF_W-1:0] c;
    } cfg_t;

    cfg_t              cfg_q, cfg_in, cfg_sel;
    logic [ACC_W-1:0]  acc_q;
    logic [WORD_W-1:0] res_q;
    logic [OPND_W-1:0] fold_x;
    logic [ACC_W-1:0]  fold_y;
    logic [ACC_W-1:0]  sub_v;
    logic [WORD_W-1:0] sub_r;
    logic fold_fresh, fold_en, res_fold, res_sub, settle_go, full_w;

    pmr_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .op_i         (pmr_op_e'(op_i)),
        .fold_fresh_o (fold_fresh),
        .fold_en_o    (fold_en),
        .res_fold_o   (res_fold),
        .res_sub_o    (res_sub),
        .settle_o     (settle_go),
        .full_o       (full_w),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    always_comb begin
        cfg_in  = '{n: exp_n_i, c: coef_c_i};
        cfg_sel = (fold_fresh || settle_go) ? cfg_in : cfg_q;
        fold_x  = fold_fresh ? operand_i : OPND_W'(acc_q);
        sub_v   = settle_go ? ACC_W'(res_q) : acc_q;
    end

    pmr_fold #(
        .IN_W   (OPND_W),
        .OUT_W  (ACC_W),
        .EXP_W  (EXP_W),
        .COEF_W (COEF_W)
    ) u_fold (
        .x_i (fold_x),
        .n_i (cfg_sel.n),
        .c_i (cfg_sel.c),
        .y_o (fold_y)
    );

    pmr_csub #(
        .WORD_W (WORD_W),
        .ACC_W  (ACC_W),
        .EXP_W  (EXP_W),
        .COEF_W (COEF_W)
    ) u_csub (
        .v_i (sub_v),
        .n_i (cfg_sel.n),
        .c_i (cfg_sel.c),
        .r_o (sub_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (fold_fresh || settle_go) cfg_q <= cfg_in;
            if (fold_en) acc_q <= fold_y;
            if (res_fold) res_q <= WORD_W'(fold_y);
            else if (res_sub || settle_go) res_q <= sub_r;
        end
    end

    assign result_o = res_q;
endmodule

// File: rtl/pmr_reduce_chk.sv
`timescale 1ns/1ps
module pmr_reduce_chk #(
    parameter int WORD_W = 32,
    parameter int EXP_W  = 6,
    parameter int COEF_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] result_o,
    input logic              full_q,
    input logic [EXP_W-1:0]  cfg_n,
    input logic [COEF_W-1:0] cfg_c
);
    logic [WORD_W:0] mod_p;
    assign mod_p = ((WORD_W+1)'(1) << cfg_n) - (WORD_W+1)'(cfg_c);

    assert_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && full_q) |-> ({1'b0, result_o} < mod_p));

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_full_latency_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_o) && full_q) |=> busy_o ##1 busy_o ##1 (done_o && !busy_o));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o || $past(start_i)));

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    assert_fold_latency_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_o) && !full_q) |=> busy_o ##1 (done_o && !busy_o));

    assert_settle_fast_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && op_i == 2'd2) |=> (done_o && !busy_o));
endmodule

bind pmr_reduce pmr_reduce_chk #(
    .WORD_W (WORD_W),
    .EXP_W  (EXP_W),
    .COEF_W (COEF_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .full_q   (full_w),
    .cfg_n    (cfg_q.n),
    .cfg_c    (cfg_q.c)
);

// File: tb/pmr_reduce_tb_top.sv
`timescale 1ns/1ps
module pmr_reduce_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [63:0] opnd = 64'd0;
    logic [5:0]  en = 6'd0;
    logic [14:0] ec = 15'd0;
    logic        busy, done;
    logic [31:0] res;
    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pmr_reduce dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .op_i      (op),
        .operand_i (opnd),
        .exp_n_i   (en),
        .coef_c_i  (ec),
        .busy_o    (busy),
        .done_o    (done),
        .result_o  (res)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] modp(input int n, input logic [14:0] c);
        return (64'd1 << n) - 64'(c);
    endfunction

    function automatic logic [63:0] bfold(input logic [63:0] x, input int n, input logic [14:0] c);
        logic [63:0] lo, hi;
        lo = x & ((64'd1 << n) - 64'd1);
        hi = x >> n;
        return lo + hi * 64'(c);
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [63:0] x, input int n, input logic [14:0] c,
                          input bit poke, output logic [31:0] r, output int lat, output bit busy_ok);
        @(negedge clk);
        start = 1'b1; op = o; opnd = x; en = 6'(n); ec = c;
        @(negedge clk);
        start = 1'b0; lat = 1; busy_ok = 1'b1;
        while (!done && lat < 20) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && lat == 1) begin
                start = 1'b1; op = 2'd0; opnd = ~x; en = 6'd32; ec = 15'd7;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        r = res;
        if (busy) busy_ok = 1'b0;
        @(negedge clk);
        chk(!done, "R4 done width", 64'(done), 64'd0);
    endtask

    task automatic full_case(input logic [1:0] o, input logic [63:0] x, input int n, input logic [14:0] c,
                             input bit poke, input string tag);
        logic [31:0] r; int lat; bit bok; logic [63:0] exp;
        exp = x % modp(n, c);
        run_op(o, x, n, c, poke, r, lat, bok);
        chk(64'(r) == exp, tag, 64'(r), exp);
        chk(lat == 4, "R3 full latency", 64'(lat), 64'd4);
        chk(bok, "R3 busy pattern", 64'(bok), 64'd1);
    endtask

    task automatic rand_cfg(output int n, output logic [14:0] c, output logic [63:0] x);
        int k, cmax;
        logic [63:0] m2;
        n = 2 + int'($urandom % 31);
        k = n / 2;
        cmax = (1 << k) - 1;
        if (cmax > 32767) cmax = 32767;
        c = 15'(1 + ($urandom % cmax));
        m2 = (n == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * n)) - 64'd1);
        if ($urandom % 4 == 0) x = (modp(n, c) * 64'($urandom % (1 << k))) + 64'($urandom % 3);
        else x = {$urandom, $urandom};
        x = x & m2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] r, held; int lat; bit bok; int n; logic [14:0] c; logic [63:0] x, e;
        void'($urandom(32'd20040927));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        chk(res == 32'd0, "R1 result after reset", 64'(res), 64'd0);

        // R6 small modulus 31, and boundaries
        full_case(2'd0, 64'd30, 5, 15'd1, 1'b0, "R6 below p");
        full_case(2'd0, 64'd31, 5, 15'd1, 1'b0, "R6 equal p");
        full_case(2'd0, 64'd1000, 5, 15'd1, 1'b0, "R2 small n");
        full_case(2'd0, 64'd1023, 5, 15'd1, 1'b0, "R2 top of 2n range");
        full_case(2'd0, 64'd15, 2, 15'd1, 1'b0, "R2 n=2");
        full_case(2'd0, 64'd65279, 16, 15'd255, 1'b0, "R2 n=16 c=255");
        // R7 full-width operands with n = 32
        full_case(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32, 15'd5, 1'b0, "R7 all ones");
        full_case(2'd0, 64'h0000_0001_0000_0000, 32, 15'd5, 1'b0, "R7 two to the 32");
        full_case(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32, 15'd32767, 1'b0, "R7 all ones big c");
        full_case(2'd0, modp(32, 15'd5), 32, 15'd5, 1'b0, "R6 equal p n32");
        full_case(2'd0, modp(32, 15'd5) - 64'd1, 32, 15'd5, 1'b0, "R6 p minus one n32");
        full_case(2'd0, modp(32, 15'd5) * modp(32, 15'd5), 32, 15'd5, 1'b0, "R7 p squared");

        // R5 start pulses while busy are ignored
        for (int i = 0; i < 12; i++) begin
            rand_cfg(n, c, x);
            full_case(2'd0, x, n, c, 1'b1, "R5 ignored start");
        end

        // R2 random full reductions
        for (int i = 0; i < 150; i++) begin
            rand_cfg(n, c, x);
            full_case(2'd0, x, n, c, 1'b0, "R2 random");
        end

        // R10 op code 3 matches full
        for (int i = 0; i < 10; i++) begin
            rand_cfg(n, c, x);
            full_case(2'd3, x, n, c, 1'b0, "R10 alt full");
        end

        // R8 fold then R9 settle
        for (int i = 0; i < 40; i++) begin
            rand_cfg(n, c, x);
            if (i == 0) begin n = 32; c = 15'd5; x = modp(32, 15'd5); end
            e = bfold(bfold(bfold(x, n, c), n, c), n, c);
            run_op(2'd1, x, n, c, (i % 5 == 0), r, lat, bok);
            chk(64'(r) == e, "R8 fold value", 64'(r), e);
            chk(lat == 3, "R8 fold latency", 64'(lat), 64'd3);
            held = r;
            e = (64'(held) >= modp(n, c)) ? 64'(held) - modp(n, c) : 64'(held);
            run_op(2'd2, {$urandom, $urandom}, n, c, 1'b0, r, lat, bok);
            chk(64'(r) == e, "R9 settle value", 64'(r), e);
            chk(64'(r) == x % modp(n, c), "R9 settle residue", 64'(r), x % modp(n, c));
            chk(lat == 1, "R9 settle latency", 64'(lat), 64'd1);
            chk(bok, "R9 settle not busy", 64'(bok), 64'd1);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule